// File: doc/BRIEF.md
# Trigger Input Lockout Filter

This block cleans up an external trigger line before it reaches timer logic. The raw input is first brought into the clock domain through a two-stage synchronizer, and edges are detected on the synchronized value. The edge kind that counts as a trigger can be rising, falling or both. When the filter is enabled, the first qualifying edge is forwarded as a one-cycle pulse and opens a lockout window. During the window every further edge is dropped.

The window is timed by an 8-bit lockout counter. The counter advances once per prescaled tick, and a tick comes every ten clocks. When the counter equals an 8-bit programmable limit, the counter returns to zero and the window closes. The prescaler restarts on the edge that opens the window, so the window length is exact. It lasts `10*limit + 1` clocks, counted from the cycle that issues the forwarded pulse.

Software reaches the lockout counter and the limit through a small write/read port. The filter does not depend on any run control of the surrounding timer. When the filter is disabled, every detected edge passes through and the counter is held at zero.

Top module: `nc_glitch_guard`

## Requirements
- R1: After reset, the counter reads 0x00, the limit reads 0xFF, and `trig_out` is low.
- R2: A write with `reg_sel`=1 loads the limit. A write with `reg_sel`=0 loads the counter while the filter is enabled. `reg_rdata` shows the counter when `reg_sel`=0 and the limit when `reg_sel`=1, and it reflects a write from the next cycle on.
- R3: With the filter enabled and idle, a qualifying level change applied to `raw_in` before clock edge k produces a single-cycle pulse on `trig_out` after clock edge k+2. The two synchronizer flops plus the output register account for this delay.
- R4: The forwarded pulse starts the window with the counter at 0 and the prescaler at 0. The counter then rises by one every 10 clocks, so it reads n after 10*n clocks.
- R5: While the window is open, qualifying edges produce no pulse on `trig_out`, and the counter continues its sequence undisturbed.
- R6: One clock after the counter equals the limit, the counter reads 0 and the window is closed. An edge evaluated on that clearing clock is still dropped, and an edge evaluated one clock later is forwarded.
- R7: With `enable` low, every qualifying edge is forwarded with the R3 latency and without lockout. The counter reads 0, and counter writes are ignored.
- R8: `edge_mode` selects the qualifying edge: 2'b00 selects rising edges, 2'b01 selects falling edges, and 2'b10 or 2'b11 selects both.
- R9: With the limit at 0, the window lasts one clock. An edge evaluated two clocks after the one that opened the window is forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns on lockout filtering; low gives pass-through |
| edge_mode | input | 2 | Qualifying edge select (R8 encoding) |
| raw_in | input | 1 | Asynchronous external trigger line |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the counter, 1 selects the limit |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| trig_out | output | 1 | Filtered single-cycle trigger pulse |

## Verification
Several rules are checked by assertions on every cycle. No pulse may leave while the window is open. The counter stays zero when disabled and steps by at most one per cycle inside the window. The window closes one clock after a match. The prescaler stays within its range, and each window opening coincides with a pulse. Other behaviour can only be shown by the bench's directed scenarios: the exact pulse latency, the 10-clock tick spacing, the edge-mode selection, and the accept/drop boundary around the clearing clock. The bench compares whole 64-cycle pulse maps and counter traces against hand-derived values.

// File: rtl/nc_pkg.sv
package nc_pkg;

    localparam int CNT_W     = 8;
    localparam int TICK_DIV  = 10;
    localparam int SYNC_LEN  = 2;
    localparam logic [CNT_W-1:0] LIMIT_RST = '1;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTH2 = 2'b11
    } edge_mode_e;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_info_t;

    function automatic logic edge_qualifies(edge_info_t e, edge_mode_e m);
        case (m)
            EDGE_RISE: return e.rise;
            EDGE_FALL: return e.fall;
            default:   return e.rise | e.fall;
        endcase
    endfunction

endpackage

// File: rtl/nc_edge_sync.sv
module nc_edge_sync
    import nc_pkg::*;
#(
    parameter int STAGES = SYNC_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_i,
    output edge_info_t edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= raw_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    always_comb begin
        edge_o.rise = sync_q[STAGES-1] & ~prev_q;
        edge_o.fall = ~sync_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/nc_tick_div.sv
module nc_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) pre_q <= '0;
        else if (pre_q == LAST)         pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run_i && (pre_q == LAST);

    p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);

endmodule

// File: rtl/nc_lockout.sv
module nc_lockout
    import nc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         hit_i,
    input  logic         tick_i,
    input  logic         wr_cnt_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] limit_i,
    output logic         start_o,
    output logic         run_o,
    output logic         fire_o,
    output logic [W-1:0] count_o
);
    logic         active_q;
    logic [W-1:0] count_q;
    logic         fire_q;
    logic         match;

    assign match   = (count_q == limit_i);
    assign start_o = en_i && hit_i && !active_q;
    assign run_o   = en_i && active_q && !match;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            active_q <= 1'b0;
            count_q  <= '0;
        end else if (start_o) begin
            active_q <= 1'b1;
            count_q  <= '0;
        end else if (wr_cnt_i) begin
            count_q  <= wr_data_i;
        end else if (active_q && match) begin
            active_q <= 1'b0;
            count_q  <= '0;
        end else if (active_q && tick_i) begin
            count_q  <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        fire_q <= 1'b0;
        else if (en_i)  fire_q <= start_o;
        else            fire_q <= hit_i;
    end

    assign fire_o  = fire_q;
    assign count_o = count_q;

    // R5: nothing leaves while the window is open
    p_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (en_i && active_q) |=> !fire_q);

    // R7: disabled filter holds the counter at zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (count_q == '0 && !active_q));

    // R6: match closes the window one clock later
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (en_i && active_q && !wr_cnt_i && match) |=> (!active_q && count_q == '0));

    // R4: counter advances by at most one per clock inside the window
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en_i && active_q && !wr_cnt_i && !match) |=>
            (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

    // R3: every window opening coincides with a forwarded pulse
    p_open_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> fire_q);

endmodule

// File: rtl/nc_glitch_guard.sv
module nc_glitch_guard
    import nc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       edge_mode,
    input  logic             raw_in,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             trig_out
);
    edge_info_t       edges;
    logic             hit;
    logic             start;
    logic             run;
    logic             tick;
    logic             wr_cnt;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit_q;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_sel);

    nc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_in),
        .edge_o (edges)
    );

    assign hit    = edge_qualifies(edges, edge_mode_e'(edge_mode));
    assign wr_cnt = reg_we && (sel == SEL_COUNT);

    always_ff @(posedge clk) begin
        if (rst)                              limit_q <= LIMIT_RST;
        else if (reg_we && sel == SEL_LIMIT)  limit_q <= reg_wdata;
    end

    nc_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .restart_i (start),
        .tick_o    (tick)
    );

    nc_lockout #(.W(CNT_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .en_i      (enable),
        .hit_i     (hit),
        .tick_i    (tick),
        .wr_cnt_i  (wr_cnt),
        .wr_data_i (reg_wdata),
        .limit_i   (limit_q),
        .start_o   (start),
        .run_o     (run),
        .fire_o    (trig_out),
        .count_o   (count)
    );

    assign reg_rdata = (sel == SEL_LIMIT) ? limit_q : count;

endmodule

// File: tb/nc_glitch_guard_bench.sv
module nc_glitch_guard_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [1:0] edge_mode;
    logic       raw_in;
    logic       reg_we;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       trig_out;

    int checks = 0;
    int failures = 0;

    logic [63:0] pul;
    logic [7:0]  cnt_log [64];

    always #4 clk = ~clk;

    nc_glitch_guard u_nc_glitch_guard (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .edge_mode (edge_mode),
        .raw_in    (raw_in),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_out  (trig_out)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle(input logic en_after, input logic [1:0] mode);
        @(negedge clk);
        enable = 1'b0; raw_in = 1'b0; reg_sel = 1'b0;
        repeat (6) @(negedge clk);
        edge_mode = mode;
        enable = en_after;
        repeat (3) @(negedge clk);
    endtask

    // bit i of pat is applied at sample index i; pulses and counter recorded per index
    task automatic run_seq(input logic [63:0] pat);
        reg_sel = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            pul[i] = trig_out;
            cnt_log[i] = reg_rdata;
            raw_in = pat[i];
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(1'b0, d); chk(d == 8'h00, "R1 counter", 64'(d), 64'h00);
        rd(1'b1, d); chk(d == 8'hFF, "R1 limit", 64'(d), 64'hFF);
        chk(trig_out == 1'b0, "R1 trig_out", 64'(trig_out), 64'h0);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        settle(1'b1, 2'b00);
        wr(1'b1, 8'h5A);
        rd(1'b1, d); chk(d == 8'h5A, "R2 limit write", 64'(d), 64'h5A);
        wr(1'b0, 8'h21);
        rd(1'b0, d); chk(d == 8'h21, "R2 counter write", 64'(d), 64'h21);
        rd(1'b1, d); chk(d == 8'h5A, "R2 limit unchanged", 64'(d), 64'h5A);
    endtask

    task automatic t_window;
        logic [63:0] pat;
        logic [63:0] exp;
        settle(1'b1, 2'b00);
        wr(1'b1, 8'd3);
        @(negedge clk);
        // rise@0 (pulse 3), rise@15 masked (R5), rise@31 evaluated on clearing clock (R6 drop), rise@34 accepted (pulse 37)
        pat = '0;
        for (int i = 0;  i <= 9;  i++) pat[i] = 1'b1;
        for (int i = 15; i <= 20; i++) pat[i] = 1'b1;
        pat[31] = 1'b1;
        for (int i = 34; i <= 39; i++) pat[i] = 1'b1;
        run_seq(pat);
        exp = (64'd1 << 3) | (64'd1 << 37);
        chk(pul == exp, "R3/R5/R6 pulse map", pul, exp);
        chk(cnt_log[12] == 8'd0, "R4 count before first tick", 64'(cnt_log[12]), 64'd0);
        chk(cnt_log[13] == 8'd1, "R4 first tick", 64'(cnt_log[13]), 64'd1);
        chk(cnt_log[23] == 8'd2, "R5 count undisturbed", 64'(cnt_log[23]), 64'd2);
        chk(cnt_log[33] == 8'd3, "R4 count reaches limit", 64'(cnt_log[33]), 64'd3);
        chk(cnt_log[34] == 8'd0, "R6 clear after match", 64'(cnt_log[34]), 64'd0);
    endtask

    task automatic t_zero_limit;
        logic [63:0] exp;
        settle(1'b1, 2'b00);
        wr(1'b1, 8'd0);
        @(negedge clk);
        run_seq(64'b101);
        exp = (64'd1 << 3) | (64'd1 << 5);
        chk(pul == exp, "R9 one-clock window", pul, exp);
    endtask

    task automatic t_modes;
        logic [63:0] exp;
        settle(1'b1, 2'b01);
        run_seq(64'h1F);
        exp = 64'd1 << 8;
        chk(pul == exp, "R8 falling only", pul, exp);
        settle(1'b1, 2'b10);
        run_seq(64'h1F);
        exp = (64'd1 << 3) | (64'd1 << 8);
        chk(pul == exp, "R8 both edges", pul, exp);
    endtask

    task automatic t_disabled;
        logic [63:0] exp;
        logic [7:0] d;
        logic       all_zero;
        settle(1'b1, 2'b00);
        wr(1'b1, 8'd3);
        settle(1'b0, 2'b00);
        wr(1'b0, 8'h44);
        rd(1'b0, d); chk(d == 8'h00, "R7 counter write ignored", 64'(d), 64'h0);
        run_seq(64'b10011);
        exp = (64'd1 << 3) | (64'd1 << 7);
        chk(pul == exp, "R7 pass-through", pul, exp);
        all_zero = 1'b1;
        for (int i = 0; i < 64; i++) if (cnt_log[i] != 8'd0) all_zero = 1'b0;
        chk(all_zero, "R7 counter held at zero", 64'(all_zero), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b0; edge_mode = 2'b00; raw_in = 1'b0;
        reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_window;
        t_zero_limit;
        t_modes;
        t_disabled;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule